// File: doc/BRIEF.md
# FIFO Programmable Threshold Offset Registers

This block sits next to the storage array of a synchronous FIFO. It holds two threshold offsets: a low-water offset used by the empty side and a high-water offset used by the full side. Software or a board controller programs them through the FIFO's ordinary data ports. While the configuration strobe `cfg_sel` is high, each write-enabled write clock edge stores the next slice of an offset from `wr_data`. Each read-enabled read clock edge returns the next slice on `rd_data`, in the same order. A small per-domain sequence pointer selects the slice. It wraps after the last slice and returns to the first slice on reset.

With the configuration strobe high, the write and read enables are withheld from the storage array, so programming never disturbs queued data or the fill level. The block also registers an almost-full indication in the write clock domain. The indication compares the write-side fill count with the effective depth minus the high-water offset. The effective depth is `DEPTH`, or `DEPTH + 1` when the `FWFT` parameter selects an output register that holds one extra word.

The bus-width select chooses how each offset is split. In wide mode an offset is carried as two 6-bit slices. In narrow mode it is carried as three 4-bit slices, which adds one cycle per offset.

Top module: `fifo_ofs_regs`

## Requirements
- R1: A synchronous active-low reset sets both sequence pointers to the first slice, clears `rd_data` and `almost_full`, and sets both offsets to 127.
- R2: In wide mode (`narrow_mode`=0), each write clock edge with `cfg_sel` and `wr_en` both high stores `wr_data[5:0]` into the slice at the write pointer and advances the pointer. The slice order is: low-water bits [5:0], low-water bits [11:6], high-water bits [5:0], high-water bits [11:6]. The other data bits are ignored.
- R3: In narrow mode (`narrow_mode`=1), a loading edge stores `wr_data[3:0]`. The slice order is: low-water bits [3:0], [7:4], [11:8], then high-water bits [3:0], [7:4], [11:8]. A full load therefore takes six edges.
- R4: After the last slice of the sequence (the fourth in wide mode, the sixth in narrow mode), the next load or readback goes to the first slice again.
- R5: Edges where `cfg_sel` is low, and edges where the matching enable is low, neither move a sequence pointer nor change an offset.
- R6: Each read clock edge with `cfg_sel` and `rd_en` both high loads `rd_data` with the slice at the read pointer, zero-extended and in the same order as R2/R3, then advances the read pointer. At all other read edges `rd_data` holds its value.
- R7: `fifo_wr_en` equals `wr_en` with `cfg_sel` low, and `fifo_rd_en` equals `rd_en` with `cfg_sel` low. Both are combinational.
- R8: At each write clock edge `almost_full` is loaded with (`fill_cnt` + high-water offset >= D). D is `DEPTH`, plus 1 when `FWFT` is set.
- R9: Once `fill_cnt` falls below D minus the offset, `almost_full` stays high until the next write clock edge and goes low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| cfg_sel | input | 1 | Configuration strobe: redirects enabled transfers to the offset registers |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| narrow_mode | input | 1 | 1: three 4-bit slices per offset; 0: two 6-bit slices |
| wr_data | input | DW | Write data bus |
| fill_cnt | input | CW | Words currently held, write-clock domain |
| rd_data | output | DW | Offset slice read back |
| almost_full | output | 1 | Registered high-water indication |
| fifo_wr_en | output | 1 | Write enable passed to the storage array |
| fifo_rd_en | output | 1 | Read enable passed to the storage array |

## Verification
The embedded properties check the following on every cycle:
- each pointer holds when idle and wraps from its last slice;
- the offsets and `rd_data` stay stable without a configuration transfer;
- the first wide slice and the last narrow slice land in the right bits;
- the readback upper bits stay zero;
- `almost_full` follows the threshold one write edge later.

Only the bench scenarios can show that a whole multi-slice sequence is read back in load order after unrelated traffic, and that a mode switch changes the slice count. They also show that the flag edge moves with a newly loaded offset and that the defaults appear after reset.

// File: rtl/ofs_seq_pkg.sv
// Package: shared types and helpers for the offset slice sequence.
// Assumes at most six slices per sequence (three per offset).
package ofs_seq_pkg;

    localparam int SEQ_PTR_W = 3;

    typedef logic [SEQ_PTR_W-1:0] seq_ptr_t;

    typedef struct packed {
        logic       is_hi;  // 0: low-water offset, 1: high-water offset
        logic [1:0] part;   // slice index inside the offset
    } seq_sel_t;

    // Index of the final slice for the selected bus mode.
    function automatic seq_ptr_t seq_last(input logic narrow);
        return narrow ? seq_ptr_t'(5) : seq_ptr_t'(3);
    endfunction

    // Next pointer value, wrapping after the final slice.
    function automatic seq_ptr_t seq_next(input seq_ptr_t p, input logic narrow);
        return (p >= seq_last(narrow)) ? '0 : p + seq_ptr_t'(1);
    endfunction

    // Split a pointer into offset select and slice index.
    function automatic seq_sel_t seq_decode(input seq_ptr_t p, input logic narrow);
        seq_sel_t s;
        seq_ptr_t per;
        per     = narrow ? seq_ptr_t'(3) : seq_ptr_t'(2);
        s.is_hi = (p >= per);
        s.part  = s.is_hi ? 2'(p - per) : 2'(p);
        return s;
    endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
// Module: slice sequence pointer for one clock domain.
// Advances once per configuration transfer and wraps after the last slice.
// Assumes narrow stays constant while a sequence is in progress.
module ofs_seq_ptr
    import ofs_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  logic     narrow,
    output seq_ptr_t ptr
);

    // Pointer register: clear on reset, step on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= seq_next(ptr, narrow);
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr)); // R5
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == seq_last(narrow)) |=> (ptr == '0)); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr < seq_last(narrow)) |=> (ptr == $past(ptr) + seq_ptr_t'(1))); // R2

endmodule

// File: rtl/ofs_load_regs.sv
// Module: the two threshold offset registers, loaded slice by slice from
// the write bus in the write clock domain.
// Assumes OFS_W is a multiple of 6 and DW >= OFS_W/2.
module ofs_load_regs
    import ofs_seq_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int DW      = 18,
    parameter int DEF_OFS = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             narrow,
    input  seq_ptr_t         ptr,
    input  logic [DW-1:0]    wdata,
    output logic [OFS_W-1:0] lo_ofs,
    output logic [OFS_W-1:0] hi_ofs
);

    localparam int WS = OFS_W / 2;
    localparam int NS = OFS_W / 3;

    seq_sel_t         sel;
    logic [OFS_W-1:0] ofs_q [2];

    // Decode which offset and slice the current load targets.
    assign sel = seq_decode(ptr, narrow);

    // Offset storage: defaults on reset, one slice replaced per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q[0] <= OFS_W'(DEF_OFS);
            ofs_q[1] <= OFS_W'(DEF_OFS);
        end else if (ld) begin
            if (narrow) begin
                if (sel.part < 2'd3) begin
                    ofs_q[sel.is_hi][int'(sel.part)*NS +: NS] <= wdata[NS-1:0];
                end
            end else if (sel.part < 2'd2) begin
                ofs_q[sel.is_hi][int'(sel.part)*WS +: WS] <= wdata[WS-1:0];
            end
        end
    end

    // Expose the stored offsets.
    assign lo_ofs = ofs_q[0];
    assign hi_ofs = ofs_q[1];

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(lo_ofs) && $stable(hi_ofs))); // R5
    AST_WIDE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !narrow && ptr == '0) |=> (lo_ofs[WS-1:0] == $past(wdata[WS-1:0]))); // R2
    AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && narrow && ptr == seq_ptr_t'(2)) |=> (lo_ofs[OFS_W-1 -: NS] == $past(wdata[NS-1:0]))); // R3

endmodule

// File: rtl/ofs_readback.sv
// Module: presents offset slices on the read bus in the read clock domain.
// Assumes the offsets are quiet (not being loaded) during a readback.
module ofs_readback
    import ofs_seq_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int DW    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             narrow,
    input  seq_ptr_t         ptr,
    input  logic [OFS_W-1:0] lo_ofs,
    input  logic [OFS_W-1:0] hi_ofs,
    output logic [DW-1:0]    rd_data
);

    localparam int WS = OFS_W / 2;
    localparam int NS = OFS_W / 3;

    seq_sel_t         sel;
    logic [OFS_W-1:0] src;
    logic [OFS_W-1:0] shifted;
    logic [WS-1:0]    word;

    // Select the addressed slice and right-align it.
    always_comb begin
        sel     = seq_decode(ptr, narrow);
        src     = sel.is_hi ? hi_ofs : lo_ofs;
        shifted = src >> (int'(sel.part) * (narrow ? NS : WS));
        word    = narrow ? WS'(shifted[NS-1:0]) : shifted[WS-1:0];
    end

    // Output register: cleared on reset, loaded on each readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd) begin
            rd_data <= DW'(word);
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rd_data)); // R6
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:WS] == '0); // R6
    AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !narrow && ptr == '0) |=> (rd_data == DW'($past(lo_ofs[WS-1:0])))); // R6

endmodule

// File: rtl/ofs_afull_gen.sv
// Module: registered almost-full indication in the write clock domain.
// Assumes fill_cnt is already synchronous to the write clock.
module ofs_afull_gen #(
    parameter int DEPTH = 4096,
    parameter bit FWFT  = 1'b0,
    parameter int OFS_W = 12,
    parameter int CW    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    fill_cnt,
    input  logic [OFS_W-1:0] hi_ofs,
    output logic             almost_full
);

    localparam int D  = DEPTH + (FWFT ? 1 : 0);
    localparam int SW = ((CW > OFS_W) ? CW : OFS_W) + 1;

    logic [SW-1:0] level;
    logic          hit;

    // Compare fill + offset with depth (avoids a negative D - m).
    assign level = SW'(fill_cnt) + SW'(hi_ofs);
    assign hit   = (level >= SW'(D));

    // Flag register: updates on write clock edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            almost_full <= 1'b0;
        end else begin
            almost_full <= hit;
        end
    end

    AST_AF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (SW'(fill_cnt) + SW'(hi_ofs) >= SW'(D)) |=> almost_full); // R8
    AST_AF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (SW'(fill_cnt) + SW'(hi_ofs) < SW'(D)) |=> !almost_full); // R9

endmodule

// File: rtl/fifo_ofs_regs.sv
// Module: top of the threshold offset block. Routes configuration transfers
// to the offset registers, gates the storage enables and drives the flag.
// Assumes narrow_mode is static during a sequence and rst_n spans edges of
// both clocks.
module fifo_ofs_regs
    import ofs_seq_pkg::*;
#(
    parameter int DEPTH   = 4096,
    parameter bit FWFT    = 1'b0,
    parameter int OFS_W   = 12,
    parameter int DW      = 18,
    parameter int DEF_OFS = 127,
    localparam int CW     = $clog2(DEPTH + 2)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          cfg_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          narrow_mode,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] fill_cnt,
    output logic [DW-1:0] rd_data,
    output logic          almost_full,
    output logic          fifo_wr_en,
    output logic          fifo_rd_en
);

    logic             ld_w;
    logic             ld_r;
    seq_ptr_t         wptr;
    seq_ptr_t         rptr;
    logic [OFS_W-1:0] lo_ofs;
    logic [OFS_W-1:0] hi_ofs;

    // Split each enable between offset access and storage access.
    assign ld_w       = cfg_sel & wr_en;
    assign ld_r       = cfg_sel & rd_en;
    assign fifo_wr_en = wr_en & ~cfg_sel;
    assign fifo_rd_en = rd_en & ~cfg_sel;

    ofs_seq_ptr u_wptr (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .adv    (ld_w),
        .narrow (narrow_mode),
        .ptr    (wptr)
    );

    ofs_seq_ptr u_rptr (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .adv    (ld_r),
        .narrow (narrow_mode),
        .ptr    (rptr)
    );

    ofs_load_regs #(.OFS_W(OFS_W), .DW(DW), .DEF_OFS(DEF_OFS)) u_regs (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .ld     (ld_w),
        .narrow (narrow_mode),
        .ptr    (wptr),
        .wdata  (wr_data),
        .lo_ofs (lo_ofs),
        .hi_ofs (hi_ofs)
    );

    ofs_readback #(.OFS_W(OFS_W), .DW(DW)) u_rb (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .rd      (ld_r),
        .narrow  (narrow_mode),
        .ptr     (rptr),
        .lo_ofs  (lo_ofs),
        .hi_ofs  (hi_ofs),
        .rd_data (rd_data)
    );

    ofs_afull_gen #(.DEPTH(DEPTH), .FWFT(FWFT), .OFS_W(OFS_W), .CW(CW)) u_af (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .fill_cnt    (fill_cnt),
        .hi_ofs      (hi_ofs),
        .almost_full (almost_full)
    );

    AST_STORE_BLOCKED: assert property (@(posedge wr_clk) disable iff (!rst_n)
        cfg_sel |-> !(fifo_wr_en || fifo_rd_en)); // R7

endmodule

// File: tb/test_fifo_ofs_regs.sv
module test_fifo_ofs_regs;

    localparam int DEPTH = 4096;
    localparam int DW    = 18;
    localparam int CW    = $clog2(DEPTH + 2);

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          narrow_mode = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] fill_cnt = '0;
    logic [DW-1:0] rd_data;
    logic          almost_full;
    logic          fifo_wr_en;
    logic          fifo_rd_en;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    int m_ofs [2];
    int m_wp, m_rp, m_rd;
    int m_af;

    fifo_ofs_regs i_fifo_ofs_regs (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
        .wr_en(wr_en), .rd_en(rd_en), .narrow_mode(narrow_mode),
        .wr_data(wr_data), .fill_cnt(fill_cnt), .rd_data(rd_data),
        .almost_full(almost_full), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #5 rd_clk = ~rd_clk;
    end

    // Model, write side
    always @(posedge wr_clk) begin : model_wr
        int per, sz, k, w, mask;
        if (!rst_n) begin
            m_ofs[0] = 127; m_ofs[1] = 127; m_wp = 0; m_af = 0;
        end else begin
            m_af = ((int'(fill_cnt) + m_ofs[1]) >= DEPTH) ? 1 : 0;
            if (cfg_sel && wr_en) begin
                per  = narrow_mode ? 3 : 2;
                sz   = narrow_mode ? 4 : 6;
                mask = (1 << sz) - 1;
                w    = m_wp / per;
                k    = m_wp % per;
                m_ofs[w] = (m_ofs[w] & ~(mask << (k * sz))) | ((int'(wr_data) & mask) << (k * sz));
                m_wp = (m_wp >= 2 * per - 1) ? 0 : m_wp + 1;
            end
        end
    end

    // Model, read side
    always @(posedge rd_clk) begin : model_rd
        int per, sz, k, w, mask;
        if (!rst_n) begin
            m_rp = 0; m_rd = 0;
        end else if (cfg_sel && rd_en) begin
            per  = narrow_mode ? 3 : 2;
            sz   = narrow_mode ? 4 : 6;
            mask = (1 << sz) - 1;
            w    = m_rp / per;
            k    = m_rp % per;
            m_rd = (m_ofs[w] >> (k * sz)) & mask;
            m_rp = (m_rp >= 2 * per - 1) ? 0 : m_rp + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to the next write-clock falling edge and compare with the model
    task automatic cyc();
        @(negedge wr_clk);
        check("R6 rd_data vs model", int'(rd_data), m_rd);
        check("R8 almost_full vs model", int'(almost_full), m_af);
        check("R7 fifo_wr_en", int'(fifo_wr_en), int'(wr_en && !cfg_sel));
        check("R7 fifo_rd_en", int'(fifo_rd_en), int'(rd_en && !cfg_sel));
    endtask

    task automatic load(input int v);
        cfg_sel = 1'b1; wr_en = 1'b1; rd_en = 1'b0;
        wr_data = DW'(18'h3FFC0 | v);
        #1;
        check("R7 store write blocked during load", int'(fifo_wr_en), 0);
        cyc();
        cfg_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic read_exp(input string req, input int exp);
        cfg_sel = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
        cyc();
        check(req, int'(rd_data), exp);
        cfg_sel = 1'b0; rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state and default offsets (127 = slices 63,1)
        check("R1 rd_data after reset", int'(rd_data), 0);
        check("R1 almost_full after reset", int'(almost_full), 0);
        read_exp("R1 default low-water lo", 63);
        read_exp("R1 default low-water hi", 1);
        read_exp("R1 default high-water lo", 63);
        read_exp("R1 default high-water hi", 1);

        // R2: wide load, upper data bits ignored
        load(42); load(5); load(17); load(3);
        read_exp("R2 wide slice 0", 42);
        read_exp("R2 wide slice 1", 5);
        read_exp("R2 wide slice 2", 17);
        read_exp("R2 wide slice 3", 3);

        // R8/R9: offset 209, threshold 3887
        fill_cnt = CW'(3886); cyc(); cyc();
        check("R8 below threshold", int'(almost_full), 0);
        fill_cnt = CW'(3887); cyc();
        check("R8 at threshold", int'(almost_full), 1);
        fill_cnt = CW'(3886);
        #1;
        check("R9 held until write edge", int'(almost_full), 1);
        cyc();
        check("R9 cleared after one edge", int'(almost_full), 0);
        fill_cnt = '0; cyc();

        // R5: traffic without strobe, strobe without enables
        wr_en = 1'b1; wr_data = DW'(18'h2AAAA);
        repeat (3) cyc();
        check("R7 store write passes", int'(fifo_wr_en), 1);
        wr_en = 1'b0; rd_en = 1'b1;
        repeat (2) cyc();
        check("R5 rd_data unchanged without strobe", int'(rd_data), 3);
        rd_en = 1'b0; cfg_sel = 1'b1;
        repeat (2) cyc();
        cfg_sel = 1'b0;
        read_exp("R5 offsets kept, slice 0", 42);
        read_exp("R5 offsets kept, slice 1", 5);
        read_exp("R5 offsets kept, slice 2", 17);
        read_exp("R5 offsets kept, slice 3", 3);

        // R3: narrow load, six slices
        narrow_mode = 1'b1; cyc();
        load(12); load(2); load(9); load(1); load(0); load(0);
        read_exp("R3 narrow slice 0", 12);
        read_exp("R3 narrow slice 1", 2);
        read_exp("R3 narrow slice 2", 9);
        read_exp("R3 narrow slice 3", 1);
        read_exp("R3 narrow slice 4", 0);
        read_exp("R3 narrow slice 5", 0);
        fill_cnt = CW'(4094); cyc(); cyc();
        check("R8 offset 1 below", int'(almost_full), 0);
        fill_cnt = CW'(4095); cyc();
        check("R8 offset 1 at threshold", int'(almost_full), 1);
        fill_cnt = '0; cyc();

        // R4: seventh load wraps onto the first slice
        load(3); load(0); load(0); load(0); load(0); load(0); load(7);
        read_exp("R4 wrapped slice 0", 7);
        for (int i = 0; i < 5; i++) read_exp("R4 slice zero", 0);
        read_exp("R4 readback wrap", 7);
        fill_cnt = CW'(4095); cyc(); cyc();
        check("R8 offset 0 below depth", int'(almost_full), 0);
        fill_cnt = CW'(4096); cyc();
        check("R8 offset 0 at depth", int'(almost_full), 1);
        cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule